// File: doc/BRIEF.md
# Cycle Stamp Counter with Read-Consistency Flag

This block is a free-running cycle counter, split into a low half and a high half, that software reads one 32-bit word at a time over a simple auxiliary register port. Because the two halves come out in separate accesses, a carry from the low half into the high half can fall between the two reads. When that happens the two words do not belong to the same count.

The block does not latch a snapshot. It watches for carries instead. Reading the low word arms a tracker. Reading the high word completes the pair. A later read of the control word reports in its top bit whether any low-to-high carry happened since the low word was read. Software reads low, then high, then control, and repeats the three reads whenever the flag comes back clear.

Counting starts and stops through an enable bit in the control word. While counting is stopped, the count holds its value. The split point between the halves is a parameter. The default is 32 low bits and 32 high bits.

Top module: `stamp_counter`

## Requirements
- R1: The control word sits at address 0x103, the low word at 0x104 and the high word at 0x105. `aux_rdata` shows the addressed word in the cycle `aux_rd` is high. It reads 0 when `aux_rd` is low or the address is unmapped. Writes to unmapped addresses change nothing.
- R2: A write to the control word loads the enable from data bit 0 and ignores bits 31:1. In the control word, bit 0 reads back the enable and bits 30:1 read as 0.
- R3: While enabled, the count rises by one on every clock and wraps at its full width. The low word returns count bits LOW_W-1:0, zero-extended (bits 31:0 by default). The high word returns the bits above them (63:32 by default).
- R4: While disabled, the count holds its value.
- R5: Reset clears the count, the enable and the tracker, so a control read right after reset returns 0.
- R6: Control bit 31 reads 1 when a low read was followed by a high read and no carry from the low half into the high half occurred from the clock edge of that low read up to the control read.
- R7: Control bit 31 reads 0 if such a carry occurred at the edge of the low read, between the reads, at the edge of the high read, or after it, before the control read.
- R8: Control bit 31 reads 0 if no high read followed the most recent low read. This includes the case where no low read has happened since reset and the case where the low word was read again after the high word.
- R9: Reading the control word leaves the tracker unchanged, so a repeated control read with no carry between returns the same bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| aux_addr | input | 12 | Register address |
| aux_rd | input | 1 | Read strobe; side effects of the read take place at the next rising edge |
| aux_wr | input | 1 | Write strobe |
| aux_wdata | input | 32 | Write data |
| aux_rdata | output | 32 | Read data, combinational from address and current state |

## Verification
The hardest case to reach is a carry into the high half that lands inside the three-read window. With 32 low bits this would take billions of cycles. The bench therefore builds the block with an 8-bit low half, so a carry comes every 256 enabled cycles. Directed sequences then wait until the bench's own count model sits one, two or several steps before the low half wraps, and start the low read there. This puts the carry on the low-read edge, on the high-read edge, and between the reads. Random operation mixes then run across many further wraps, with pauses of random length and enable toggles.

// File: rtl/stamp_counter_pkg.sv
`timescale 1ns/1ps
package stamp_counter_pkg;
   localparam int REG_W   = 32;
   localparam int AUX_AW  = 12;
   localparam int EN_BIT  = 0;
   localparam int OK_BIT  = 31;

   localparam logic [AUX_AW-1:0] ADDR_CTRL = 12'h103;
   localparam logic [AUX_AW-1:0] ADDR_LO   = 12'h104;
   localparam logic [AUX_AW-1:0] ADDR_HI   = 12'h105;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_LO   = 2'd2,
      SEL_HI   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/stamp_counter_decode.sv
`timescale 1ns/1ps
module stamp_counter_decode
   import stamp_counter_pkg::*;
(
   input  logic [AUX_AW-1:0] addr,
   output reg_sel_e          sel
);
   always_comb begin
      unique case (addr)
         ADDR_CTRL: sel = SEL_CTRL;
         ADDR_LO:   sel = SEL_LO;
         ADDR_HI:   sel = SEL_HI;
         default:   sel = SEL_NONE;
      endcase
   end
endmodule

// File: rtl/stamp_counter_core.sv
`timescale 1ns/1ps
module stamp_counter_core
   import stamp_counter_pkg::*;
#(
   parameter int LOW_W  = 32,
   parameter int HIGH_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              count_en,
   output logic [LOW_W-1:0]  cnt_lo,
   output logic [HIGH_W-1:0] cnt_hi,
   output logic              carry,
   output logic [REG_W-1:0]  lo_word,
   output logic [REG_W-1:0]  hi_word
);
   // carry into the high half happens on the edge where the low half wraps
   assign carry = count_en & (&cnt_lo);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_lo <= '0;
         cnt_hi <= '0;
      end else if (count_en) begin
         cnt_lo <= cnt_lo + 1'b1;
         if (carry) cnt_hi <= cnt_hi + 1'b1;
      end
   end

   generate
      if (LOW_W == REG_W) begin : g_lo_full
         assign lo_word = cnt_lo;
      end else begin : g_lo_pad
         assign lo_word = {{(REG_W-LOW_W){1'b0}}, cnt_lo};
      end
      if (HIGH_W == REG_W) begin : g_hi_full
         assign hi_word = cnt_hi;
      end else begin : g_hi_pad
         assign hi_word = {{(REG_W-HIGH_W){1'b0}}, cnt_hi};
      end
   endgenerate
endmodule

// File: rtl/stamp_counter_track.sv
`timescale 1ns/1ps
module stamp_counter_track (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_lo,
   input  logic rd_hi,
   input  logic carry,
   output logic pair_ok
);
   logic lo_seen, hi_seen, disturbed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_seen   <= 1'b0;
         hi_seen   <= 1'b0;
         disturbed <= 1'b0;
      end else if (rd_lo) begin
         lo_seen   <= 1'b1;
         hi_seen   <= 1'b0;
         disturbed <= carry;
      end else begin
         if (rd_hi) hi_seen <= lo_seen;
         if (carry) disturbed <= 1'b1;
      end
   end

   assign pair_ok = lo_seen & hi_seen & ~disturbed;
endmodule

// File: rtl/stamp_counter.sv
`timescale 1ns/1ps
module stamp_counter
   import stamp_counter_pkg::*;
#(
   parameter int LOW_W  = 32,
   parameter int HIGH_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AUX_AW-1:0] aux_addr,
   input  logic              aux_rd,
   input  logic              aux_wr,
   input  logic [REG_W-1:0]  aux_wdata,
   output logic [REG_W-1:0]  aux_rdata
);
   generate
      if (LOW_W < 1 || LOW_W > REG_W) begin : g_bad_low
         $error("stamp_counter: LOW_W must lie in 1..32");
      end
      if (HIGH_W < 1 || HIGH_W > REG_W) begin : g_bad_high
         $error("stamp_counter: HIGH_W must lie in 1..32");
      end
   endgenerate

   reg_sel_e          sel;
   logic              en_q;
   logic [LOW_W-1:0]  cnt_lo;
   logic [HIGH_W-1:0] cnt_hi;
   logic              cnt_carry;
   logic [REG_W-1:0]  lo_word, hi_word;
   logic              trk_ok;
   logic              rd_lo, rd_hi, wr_ctrl;
   logic              unused_wdata;

   assign unused_wdata = ^aux_wdata[REG_W-1:1];

   stamp_counter_decode i_decode (
      .addr (aux_addr),
      .sel  (sel)
   );

   assign rd_lo   = aux_rd && (sel == SEL_LO);
   assign rd_hi   = aux_rd && (sel == SEL_HI);
   assign wr_ctrl = aux_wr && (sel == SEL_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n)       en_q <= 1'b0;
      else if (wr_ctrl) en_q <= aux_wdata[EN_BIT];
   end

   stamp_counter_core #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) i_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_en (en_q),
      .cnt_lo   (cnt_lo),
      .cnt_hi   (cnt_hi),
      .carry    (cnt_carry),
      .lo_word  (lo_word),
      .hi_word  (hi_word)
   );

   stamp_counter_track i_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_lo   (rd_lo),
      .rd_hi   (rd_hi),
      .carry   (cnt_carry),
      .pair_ok (trk_ok)
   );

   always_comb begin
      aux_rdata = '0;
      if (aux_rd) begin
         unique case (sel)
            SEL_CTRL: begin
               aux_rdata[OK_BIT] = trk_ok;
               aux_rdata[EN_BIT] = en_q;
            end
            SEL_LO:   aux_rdata = lo_word;
            SEL_HI:   aux_rdata = hi_word;
            default:  aux_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/stamp_counter_chk.sv
`timescale 1ns/1ps
module stamp_counter_chk
   import stamp_counter_pkg::*;
#(
   parameter int LOW_W  = 32,
   parameter int HIGH_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic [AUX_AW-1:0] aux_addr,
   input logic              aux_rd,
   input logic              aux_wr,
   input logic              wdata_en,
   input logic [REG_W-1:0]  aux_rdata,
   input logic              en_q,
   input logic [LOW_W-1:0]  cnt_lo,
   input logic [HIGH_W-1:0] cnt_hi,
   input logic              cnt_carry,
   input logic              trk_ok
);
   localparam int CNT_W = LOW_W + HIGH_W;
   logic [CNT_W-1:0] cnt_all;
   logic             a_ctrl, a_lo, a_hi, a_none;

   assign cnt_all = {cnt_hi, cnt_lo};
   assign a_ctrl  = (aux_addr == ADDR_CTRL);
   assign a_lo    = (aux_addr == ADDR_LO);
   assign a_hi    = (aux_addr == ADDR_HI);
   assign a_none  = !(a_ctrl || a_lo || a_hi);

   // R1
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_rd && a_none) |-> (aux_rdata == '0));

   // R2
   enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_wr && a_ctrl) |=> (en_q == $past(wdata_en)));

   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> (cnt_all == CNT_W'($past(cnt_all) + 1'b1)));

   // R4
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> $stable(cnt_all));

   // R7
   carry_spoils_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_carry |=> !trk_ok);

   // R8
   lo_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_rd && a_lo) |=> !trk_ok);

   // R9
   ctrl_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_rd && a_ctrl && !cnt_carry) |=> $stable(trk_ok));

   // R6
   hi_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trk_ok && !cnt_carry && !(aux_rd && a_lo)) |=> trk_ok);
endmodule

bind stamp_counter stamp_counter_chk #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .aux_addr  (aux_addr),
   .aux_rd    (aux_rd),
   .aux_wr    (aux_wr),
   .wdata_en  (aux_wdata[0]),
   .aux_rdata (aux_rdata),
   .en_q      (en_q),
   .cnt_lo    (cnt_lo),
   .cnt_hi    (cnt_hi),
   .cnt_carry (cnt_carry),
   .trk_ok    (trk_ok)
);

// File: tb/test_stamp_counter.sv
`timescale 1ns/1ps
module test_stamp_counter;
   import stamp_counter_pkg::*;

   localparam int LOW_W  = 8;
   localparam int HIGH_W = 32;
   localparam logic [LOW_W-1:0] LO_MAX = '1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [AUX_AW-1:0] aux_addr = '0;
   logic              aux_rd = 1'b0;
   logic              aux_wr = 1'b0;
   logic [REG_W-1:0]  aux_wdata = '0;
   logic [REG_W-1:0]  aux_rdata;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   stamp_counter #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) i_stamp_counter (
      .clk(clk), .rst_n(rst_n), .aux_addr(aux_addr), .aux_rd(aux_rd),
      .aux_wr(aux_wr), .aux_wdata(aux_wdata), .aux_rdata(aux_rdata)
   );

   // reference model built from the requirements
   logic [LOW_W-1:0]  m_lo = '0;
   logic [HIGH_W-1:0] m_hi = '0;
   logic m_en = 1'b0, m_los = 1'b0, m_his = 1'b0, m_dist = 1'b0;
   logic m_carry;
   assign m_carry = m_en && (m_lo == LO_MAX);

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lo <= '0; m_hi <= '0; m_en <= 1'b0;
         m_los <= 1'b0; m_his <= 1'b0; m_dist <= 1'b0;
      end else begin
         if (m_en) begin
            m_lo <= m_lo + 1'b1;
            if (m_carry) m_hi <= m_hi + 1'b1;
         end
         if (aux_wr && aux_addr == ADDR_CTRL) m_en <= aux_wdata[0];
         if (aux_rd && aux_addr == ADDR_LO) begin
            m_los <= 1'b1; m_his <= 1'b0; m_dist <= m_carry;
         end else begin
            if (aux_rd && aux_addr == ADDR_HI) m_his <= m_los;
            if (m_carry) m_dist <= 1'b1;
         end
      end
   end

   function automatic logic [REG_W-1:0] exp_read(logic [AUX_AW-1:0] a);
      logic [REG_W-1:0] v = '0;
      if (a == ADDR_CTRL) begin
         v[31] = m_los && m_his && !m_dist;
         v[0]  = m_en;
      end else if (a == ADDR_LO) v = REG_W'(m_lo);
      else if (a == ADDR_HI)     v = REG_W'(m_hi);
      return v;
   endfunction

   function automatic string req_of(logic [AUX_AW-1:0] a);
      if (a == ADDR_CTRL) return "R6/R7/R8/R2";
      if (a == ADDR_LO || a == ADDR_HI) return "R3/R4";
      return "R1";
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   // read one word, compare with model, return the value
   task automatic rd(input logic [AUX_AW-1:0] a, output logic [REG_W-1:0] v);
      logic [REG_W-1:0] e;
      aux_addr = a; aux_rd = 1'b1;
      #1;
      e = exp_read(a);
      v = aux_rdata;
      check(aux_rdata === e, req_of(a), aux_rdata, e);
      @(negedge clk);
      aux_rd = 1'b0;
   endtask

   task automatic wr(input logic [AUX_AW-1:0] a, input logic [REG_W-1:0] d);
      aux_addr = a; aux_wdata = d; aux_wr = 1'b1;
      @(negedge clk);
      aux_wr = 1'b0;
   endtask

   task automatic wait_lo(input logic [LOW_W-1:0] target);
      while (m_lo != target) idle();
   endtask

   function automatic logic [AUX_AW-1:0] rand_bad_addr();
      logic [AUX_AW-1:0] a;
      do a = AUX_AW'($urandom); while (a == ADDR_CTRL || a == ADDR_LO || a == ADDR_HI);
      return a;
   endfunction

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
   end

   initial begin
      logic [REG_W-1:0] v, v2;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R5: reset state
      rd(ADDR_CTRL, v);
      check(v == 32'h0, "R5", v, 32'h0);
      rd(ADDR_LO, v);  rd(ADDR_HI, v);
      // R1: read data quiet while strobe low
      aux_addr = ADDR_CTRL; #1;
      check(aux_rdata == 32'h0, "R1", aux_rdata, 32'h0);
      idle();

      // R4: not counting while disabled after reset
      repeat (10) idle();
      rd(ADDR_LO, v);
      check(v == 32'h0, "R4", v, 32'h0);

      // R8: low read without high read
      rd(ADDR_CTRL, v);
      check(v[31] == 1'b0, "R8", v, 32'h0);

      // R2: enable with junk in upper bits; bits 30:1 read 0
      wr(ADDR_CTRL, 32'hFFFF_FFFF);
      rd(ADDR_CTRL, v);
      check(v[30:1] == 30'h0 && v[0], "R2", v, 32'h1);

      // R6: clean sequence
      rd(ADDR_LO, v); rd(ADDR_HI, v); rd(ADDR_CTRL, v);
      check(v[31] == 1'b1, "R6", v, 32'h8000_0001);
      // R9: repeat control read keeps flag
      rd(ADDR_CTRL, v2);
      check(v2[31] == 1'b1, "R9", v2, 32'h8000_0001);

      // R8: low read again after a completed pair
      rd(ADDR_LO, v); rd(ADDR_CTRL, v);
      check(v[31] == 1'b0, "R8", v, 32'h1);

      // R7: carry on the low-read edge
      wait_lo(LO_MAX);
      rd(ADDR_LO, v); rd(ADDR_HI, v); rd(ADDR_CTRL, v);
      check(v[31] == 1'b0, "R7", v, 32'h1);
      // R7: carry on the high-read edge
      wait_lo(LO_MAX - 1);
      rd(ADDR_LO, v); rd(ADDR_HI, v); rd(ADDR_CTRL, v);
      check(v[31] == 1'b0, "R7", v, 32'h1);
      // R7: carry between the reads
      wait_lo(LO_MAX - 3);
      rd(ADDR_LO, v); repeat (6) idle(); rd(ADDR_HI, v); rd(ADDR_CTRL, v);
      check(v[31] == 1'b0, "R7", v, 32'h1);
      // R6: sequence ends just before the wrap
      wait_lo(LO_MAX - 2);
      rd(ADDR_LO, v); rd(ADDR_HI, v); rd(ADDR_CTRL, v);
      check(v[31] == 1'b1, "R6", v, 32'h8000_0001);
      // R3: high word advanced past earlier wraps
      rd(ADDR_HI, v);
      check(v != 32'h0, "R3", v, REG_W'(m_hi));

      // R1: unmapped write ignored, control still enabled
      wr(rand_bad_addr(), 32'h0);
      rd(ADDR_CTRL, v);
      check(v[0] == 1'b1, "R1", v, 32'h1);

      // R4: disable holds count
      wr(ADDR_CTRL, 32'hFFFF_FFFE);
      rd(ADDR_LO, v);
      repeat (300) idle();
      rd(ADDR_LO, v2);
      check(v == v2, "R4", v2, v);
      wr(ADDR_CTRL, 32'h1);

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         int op = int'($urandom_range(0, 11));
         case (op)
            0, 1: repeat ($urandom_range(1, 40)) idle();
            2: rd(ADDR_LO, v);
            3: rd(ADDR_HI, v);
            4: rd(ADDR_CTRL, v);
            5, 6, 7: begin rd(ADDR_LO, v); rd(ADDR_HI, v); rd(ADDR_CTRL, v); end
            8: wr(ADDR_CTRL, {$urandom_range(0, 32'h7FFF_FFFF), ($urandom_range(0, 9) != 0)});
            9: rd(rand_bad_addr(), v);
            10: wr(rand_bad_addr(), $urandom);
            default: if (m_en) begin wait_lo(LO_MAX - LOW_W'($urandom_range(0, 3)));
                        rd(ADDR_LO, v); rd(ADDR_HI, v); rd(ADDR_CTRL, v); end
         endcase
      end

      // R5: reset in mid-run clears everything
      rst_n = 1'b0; idle(); rst_n = 1'b1;
      rd(ADDR_CTRL, v);
      check(v == 32'h0, "R5", v, 32'h0);
      rd(ADDR_HI, v);
      check(v == 32'h0, "R5", v, 32'h0);

      finish_run();
   end
endmodule